// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block carries out the subroutine call and return instructions of a small 8-bit processor whose program counter and stack pointer are both 16 bits wide. The instruction decoder hands it an opcode, the program counter of that opcode and the Zero and Carry flags, with a one-cycle start strobe. The block keeps the stack pointer in its own register. It uses a byte-wide memory port to fetch the two-byte call target, to place a return address on a stack that grows toward lower addresses, or to fetch a return address back off that stack.

When the work is finished, the block presents the new program counter, the new stack pointer and the cycle cost of the instruction. It marks them with a single-cycle done pulse. Conditional forms that are not taken finish without touching memory. The flags are only read and never changed. Opcodes outside the call and return set are treated as one-byte no-ops, so the decoder always receives a done pulse.

Top module: `callret_seq`

## Requirements
- R1: After reset the stack pointer output is 0xFFFE, done is low and neither memory strobe is active.
- R2: Opcode bits [4:3] select the condition of the conditional forms: 00 = Zero clear, 01 = Zero set, 10 = Carry clear, 11 = Carry set. The conditional calls are 0xC4, 0xCC, 0xD4 and 0xDC. The conditional returns are 0xC0, 0xC8, 0xD0 and 0xD8. 0xCD is the unconditional call and 0xC9 is the unconditional return.
- R3: A taken call reads the target low byte at PC+1 and the high byte at PC+2. It loads the program counter with that target and reports a cost of 24.
- R4: A taken call pushes PC+3. The stack pointer drops by 2, the low byte is written at the new stack pointer and then the high byte at the new stack pointer plus 1. All address arithmetic wraps modulo 2^16.
- R5: A taken return reads the low byte at SP and the high byte at SP+1. It loads the program counter with that value and raises the stack pointer by 2. The cost is 16 for 0xC9 and 20 for a taken conditional return.
- R6: A call whose condition fails reports cost 12, advances the program counter by 3, leaves the stack pointer unchanged and makes no memory access.
- R7: A return whose condition fails reports cost 8, advances the program counter by 1, leaves the stack pointer unchanged and makes no memory access.
- R8: Any other opcode reports cost 4, advances the program counter by 1 and makes no memory access.
- R9: Done is high for exactly one cycle. It arrives 1 cycle after the start edge when there is no memory work, 4 cycles after it for a taken return and 6 cycles after it for a taken call. Outputs hold until the next start.
- R10: Memory moves one byte per cycle. Read and write strobes are never active together. Read data arrives in the cycle after its strobe. The two bytes of one word use consecutive addresses, low byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to execute `opcode` |
| opcode | input | 8 | Fetched instruction byte |
| pcIn | input | 16 | Address of the opcode |
| zeroFlag | input | 1 | Zero flag |
| carryFlag | input | 1 | Carry flag |
| memAddr | output | 16 | Memory byte address |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid the cycle after `memRd` |
| pcOut | output | 16 | Updated program counter |
| spOut | output | 16 | Stack pointer |
| cycleCost | output | 5 | Cycle cost of the finished instruction |
| done | output | 1 | Results valid pulse |

## Verification
Every result is due at a fixed latency after the edge that samples start. A non-memory outcome is due 1 cycle after that edge, a taken return 4 cycles after it and a taken call 6 cycles after it. The bench drives start at a falling edge and counts rising edges until done is seen at a falling edge. It compares that count with the latency implied by the opcode and flags. It reads the program counter, stack pointer, cost and the memory strobe tallies in that same done cycle, away from the clock edge. Pushed bytes are read from the bench memory model after done, by which time the last write has landed.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RDW, ST_WR0, ST_WR1, ST_FIN
  } state_e;

  typedef enum logic [2:0] {
    AD_PC1, AD_PC2, AD_SP0, AD_SP1, AD_PUSH
  } addr_sel_e;

  typedef enum logic [1:0] {
    KD_OTHER, KD_CALL, KD_RET
  } kind_e;

  typedef struct packed {
    logic      latch;
    logic [1:0] pcAdv;
    logic [4:0] cost;
    logic      rd;
    logic      wr;
    logic      wrHi;
    addr_sel_e addrSel;
    logic      capLo;
    logic      capHi;
    logic      spInc;
    logic      spDec;
    logic      fin;
  } ctl_t;

  localparam logic [4:0] COST_CALL_T = 5'd24;
  localparam logic [4:0] COST_CALL_N = 5'd12;
  localparam logic [4:0] COST_RET_U  = 5'd16;
  localparam logic [4:0] COST_RET_T  = 5'd20;
  localparam logic [4:0] COST_RET_N  = 5'd8;
  localparam logic [4:0] COST_OTHER  = 5'd4;

  function automatic logic condMet(input logic [1:0] sel, input logic z, input logic c);
    case (sel)
      2'b00:   return !z;
      2'b01:   return z;
      2'b10:   return !c;
      default: return c;
    endcase
  endfunction

endpackage

// File: rtl/callret_ctrl.sv
module callret_ctrl
  import callret_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] opcode,
  input  logic       zeroFlag,
  input  logic       carryFlag,
  output ctl_t       ctl
);

  state_e state, nextState;
  kind_e  kindReg;
  kind_e  kindDec;
  logic   takenDec;
  logic [1:0] advDec;
  logic [4:0] costDec;

  // decode of the incoming opcode
  always_comb begin
    kindDec  = KD_OTHER;
    takenDec = 1'b0;
    advDec   = 2'd1;
    costDec  = COST_OTHER;
    if (opcode == 8'hCD) begin
      kindDec = KD_CALL; takenDec = 1'b1; advDec = 2'd3; costDec = COST_CALL_T;
    end else if (opcode == 8'hC9) begin
      kindDec = KD_RET; takenDec = 1'b1; advDec = 2'd1; costDec = COST_RET_U;
    end else if (opcode[7:5] == 3'b110 && opcode[2:0] == 3'b100) begin
      kindDec  = KD_CALL;
      takenDec = condMet(opcode[4:3], zeroFlag, carryFlag);
      advDec   = 2'd3;
      costDec  = takenDec ? COST_CALL_T : COST_CALL_N;
    end else if (opcode[7:5] == 3'b110 && opcode[2:0] == 3'b000) begin
      kindDec  = KD_RET;
      takenDec = condMet(opcode[4:3], zeroFlag, carryFlag);
      advDec   = 2'd1;
      costDec  = takenDec ? COST_RET_T : COST_RET_N;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kindReg <= KD_OTHER;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) kindReg <= kindDec;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.addrSel = AD_SP0;
    nextState   = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.latch = 1'b1;
          ctl.pcAdv = advDec;
          ctl.cost  = costDec;
          nextState = (takenDec && kindDec != KD_OTHER) ? ST_RD0 : ST_FIN;
        end
      end
      ST_RD0: begin
        ctl.rd      = 1'b1;
        ctl.addrSel = (kindReg == KD_CALL) ? AD_PC1 : AD_SP0;
        nextState   = ST_RD1;
      end
      ST_RD1: begin
        ctl.rd      = 1'b1;
        ctl.addrSel = (kindReg == KD_CALL) ? AD_PC2 : AD_SP1;
        ctl.capLo   = 1'b1;
        nextState   = ST_RDW;
      end
      ST_RDW: begin
        ctl.capHi = 1'b1;
        ctl.spInc = (kindReg == KD_RET);
        nextState = (kindReg == KD_CALL) ? ST_WR0 : ST_FIN;
      end
      ST_WR0: begin
        ctl.wr      = 1'b1;
        ctl.addrSel = AD_PUSH;
        ctl.spDec   = 1'b1;
        nextState   = ST_WR1;
      end
      ST_WR1: begin
        ctl.wr      = 1'b1;
        ctl.wrHi    = 1'b1;
        ctl.addrSel = AD_SP1;
        nextState   = ST_FIN;
      end
      ST_FIN: begin
        ctl.fin   = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/callret_dpath.sv
module callret_dpath
  import callret_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] SP_RESET = 16'hFFFE
)(
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [AW-1:0] pcIn,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [AW-1:0] pcOut,
  output logic [AW-1:0] spOut,
  output logic [4:0]    cycleCost
);

  localparam int WORDB = AW / DW;
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] TWO  = AW'(2);
  localparam logic [AW-1:0] CALL_LEN = AW'(3);

  logic [AW-1:0] pcReg, spReg, pcBase, retAddr;
  logic [DW-1:0] lowByte;
  logic [DW-1:0] retBytes [WORDB];

  genvar gi;
  generate
    for (gi = 0; gi < WORDB; gi++) begin : g_split
      assign retBytes[gi] = retAddr[gi*DW +: DW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcReg     <= '0;
      spReg     <= SP_RESET;
      pcBase    <= '0;
      retAddr   <= '0;
      lowByte   <= '0;
      cycleCost <= '0;
    end else begin
      if (ctl.latch) begin
        pcBase    <= pcIn;
        retAddr   <= pcIn + CALL_LEN;
        pcReg     <= pcIn + AW'(ctl.pcAdv);
        cycleCost <= ctl.cost;
      end
      if (ctl.capLo) lowByte <= memRdata;
      if (ctl.capHi) pcReg <= {memRdata, lowByte};
      if (ctl.spInc) spReg <= spReg + TWO;
      if (ctl.spDec) spReg <= spReg - TWO;
    end
  end

  always_comb begin
    case (ctl.addrSel)
      AD_PC1:  memAddr = pcBase + ONE;
      AD_PC2:  memAddr = pcBase + TWO;
      AD_SP1:  memAddr = spReg + ONE;
      AD_PUSH: memAddr = spReg - TWO;
      default: memAddr = spReg;
    endcase
  end

  assign memWdata  = ctl.wrHi ? retBytes[1] : retBytes[0];
  assign pcOut     = pcReg;
  assign spOut     = spReg;

endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] SP_RESET = 16'hFFFE
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] opcode,
  input  logic [AW-1:0] pcIn,
  input  logic          zeroFlag,
  input  logic          carryFlag,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic          memWr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] pcOut,
  output logic [AW-1:0] spOut,
  output logic [4:0]    cycleCost,
  output logic          done
);

  ctl_t ctl;

  callret_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .zeroFlag(zeroFlag), .carryFlag(carryFlag), .ctl(ctl)
  );

  callret_dpath #(.AW(AW), .DW(DW), .SP_RESET(SP_RESET)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .pcIn(pcIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .pcOut(pcOut), .spOut(spOut),
    .cycleCost(cycleCost)
  );

  assign memRd = ctl.rd;
  assign memWr = ctl.wr;
  assign done  = ctl.fin;

endmodule

// File: rtl/callret_chk.sv
module callret_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        memRd,
  input logic        memWr,
  input logic [15:0] memAddr,
  input logic [15:0] spOut
);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(memRd && memWr));

  p_read_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memRd) |=> (memRd && memAddr == $past(memAddr) + 16'd1));

  p_write_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memWr) |=> (memWr && memAddr == $past(memAddr) + 16'd1));

  p_sp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spOut) |-> (spOut == $past(spOut) + 16'd2 || spOut == $past(spOut) - 16'd2));

  p_quiet_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!memRd && !memWr));

endmodule

bind callret_seq callret_chk u_chk (.*);

// File: tb/tb_callret_seq.sv
module tb_callret_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] pcIn = '0;
  logic        zeroFlag = 1'b0, carryFlag = 1'b0;
  logic [15:0] memAddr, pcOut, spOut;
  logic        memRd, memWr, done;
  logic [7:0]  memWdata, memRdata;
  logic [4:0]  cycleCost;

  int checks = 0, failures = 0;
  logic [7:0] mem [logic [15:0]];
  logic [15:0] expSp;

  always #10 clk = ~clk;

  callret_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pcIn(pcIn),
    .zeroFlag(zeroFlag), .carryFlag(carryFlag), .memAddr(memAddr), .memRd(memRd),
    .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata), .pcOut(pcOut),
    .spOut(spOut), .cycleCost(cycleCost), .done(done)
  );

  function automatic logic [7:0] rdMem(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  logic [7:0] rdq = '0;
  always @(posedge clk) begin
    if (memWr) mem[memAddr] = memWdata;
    if (memRd) rdq <= rdMem(memAddr);
  end
  assign memRdata = rdq;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // run one instruction and check all results against arithmetic expectations
  task automatic run(input logic [7:0] op, input logic [15:0] pc, input logic z,
                     input logic c, input logic [15:0] val);
    int kind = 0; logic taken = 1'b0; int cost = 4; int lat = 1;
    logic [15:0] ePc; int nRd = 0, nWr = 0, n = 0;
    string req;
    if (op == 8'hCD) begin kind = 1; taken = 1'b1; end
    else if (op == 8'hC9) begin kind = 2; taken = 1'b1; end
    else if (op[7:5] == 3'b110 && (op[2:0] == 3'b100 || op[2:0] == 3'b000)) begin
      kind = (op[2:0] == 3'b100) ? 1 : 2;
      case (op[4:3]) 2'b00: taken = !z; 2'b01: taken = z; 2'b10: taken = !c; default: taken = c; endcase
    end
    // R2 condition and opcode set drive the expected outcome
    if (kind == 1 && taken) begin
      req = "R3"; cost = 24; lat = 6; ePc = val;
      mem[pc + 16'd1] = val[7:0]; mem[pc + 16'd2] = val[15:8];
    end else if (kind == 1) begin
      req = "R6"; cost = 12; ePc = pc + 16'd3;
    end else if (kind == 2 && taken) begin
      req = "R5"; cost = (op == 8'hC9) ? 16 : 20; lat = 4; ePc = val;
      mem[expSp] = val[7:0]; mem[expSp + 16'd1] = val[15:8];
    end else if (kind == 2) begin
      req = "R7"; cost = 8; ePc = pc + 16'd1;
    end else begin
      req = "R8"; cost = 4; ePc = pc + 16'd1;
    end
    @(negedge clk);
    opcode = op; pcIn = pc; zeroFlag = z; carryFlag = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 20) begin
      if (memRd) nRd++;
      if (memWr) nWr++;
      @(posedge clk); @(negedge clk); n++;
    end
    chk(n == lat, "R9", "latency", n, lat);
    chk(pcOut == ePc, req, "pc", pcOut, ePc);
    chk(cycleCost == cost[4:0], req, "cost", cycleCost, cost);
    chk(nRd == (taken && kind != 0 ? 2 : 0), "R10", "reads", nRd, (taken && kind != 0) ? 2 : 0);
    chk(nWr == (taken && kind == 1 ? 2 : 0), "R10", "writes", nWr, (taken && kind == 1) ? 2 : 0);
    if (kind == 1 && taken) begin
      expSp = expSp - 16'd2;
      chk(rdMem(expSp) == pc[7:0] + 8'd3 || 1'b0 ? 1'b1 : (rdMem(expSp) == 8'((pc + 16'd3) & 16'hFF)),
          "R4", "push lo", rdMem(expSp), (pc + 16'd3) & 16'hFF);
      chk(rdMem(expSp + 16'd1) == 8'((pc + 16'd3) >> 8), "R4", "push hi",
          rdMem(expSp + 16'd1), (pc + 16'd3) >> 8);
    end else if (kind == 2 && taken) begin
      expSp = expSp + 16'd2;
    end
    chk(spOut == expSp, req, "sp", spOut, expSp);
    @(posedge clk); @(negedge clk);
    chk(!done, "R9", "done pulse width", done, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] ops [11];
    ops = '{8'hCD, 8'hC4, 8'hCC, 8'hD4, 8'hDC, 8'hC9, 8'hC0, 8'hC8, 8'hD0, 8'hD8, 8'h00};
    expSp = 16'hFFFE;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spOut == 16'hFFFE, "R1", "sp", spOut, 16'hFFFE);
    chk(!done && !memRd && !memWr, "R1", "quiet", {done, memRd, memWr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spOut == 16'hFFFE && !done, "R1", "after release", spOut, 16'hFFFE);

    // R4 push of 0x1234 lands little-endian at 0xFFFC/0xFFFD
    run(8'hCD, 16'h1231, 1'b0, 1'b0, 16'h2000);
    chk(rdMem(16'hFFFC) == 8'h34, "R4", "byte at FFFC", rdMem(16'hFFFC), 8'h34);
    chk(rdMem(16'hFFFD) == 8'h12, "R4", "byte at FFFD", rdMem(16'hFFFD), 8'h12);
    // R5 return restores the pushed address and SP
    begin
      logic [15:0] back = {rdMem(16'hFFFD), rdMem(16'hFFFC)};
      run(8'hC9, 16'h2000, 1'b0, 1'b0, back);
    end
    chk(spOut == 16'hFFFE, "R5", "sp restored", spOut, 16'hFFFE);
    // R4 wrap: return at 0xFFFE takes SP to 0x0000, then a call from PC 0xFFFE wraps
    run(8'hC9, 16'h3000, 1'b0, 1'b0, 16'h4455);
    chk(spOut == 16'h0000, "R4", "sp wrap up", spOut, 0);
    run(8'hCD, 16'hFFFE, 1'b0, 1'b0, 16'h0777);
    chk(rdMem(16'hFFFE) == 8'h01 && rdMem(16'hFFFF) == 8'h00, "R4", "wrapped push",
        {rdMem(16'hFFFF), rdMem(16'hFFFE)}, 16'h0001);

    // R2 sweep: every opcode under every flag combination
    for (int i = 0; i < 11; i++) begin
      for (int f = 0; f < 4; f++) begin
        logic [15:0] pc = 16'(16'h0100 + i * 16'h0321 + f * 16'h0047);
        logic [15:0] v  = 16'({8'(i * 37 + f), 8'(f * 11 + i + 3)});
        run(ops[i], pc, f[0], f[1], v);
      end
    end
    run(8'hC3, 16'h1000, 1'b1, 1'b1, 16'h0);
    run(8'hE9, 16'hFFFF, 1'b0, 1'b1, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule